// File: doc/BRIEF.md
# Receive Message Queue Pointer and Status Controller

This block manages a circular receive queue of message objects that sit in a separate message RAM. It does not hold the message data. The controller keeps a hardware write index, which the protocol engine uses as the RAM slot for each incoming frame. Each accepted store strobe advances that index.

Software reads a message straight from the RAM at the user address that the block presents. When it has finished with the message, it sends a one-cycle increment pulse. The pulse moves the user address on to the next object. The write index and the user pointer are kept apart, so a new frame can be stored while software is still reading an older one.

The block counts how many objects are occupied. From that count it reports not-empty, half-full and full flags, each registered. It also keeps a sticky overflow flag that records a store strobe arriving while every object is still occupied.

Top module: `rx_msg_fifo_ctrl`

## Requirements
- R1: In the first cycle after reset, all four flags are 0, the write index is 0 and the user address equals BASE_ADDR.
- R2: A store strobe while the queue is not full advances the write index by one, wrapping from DEPTH-1 to 0. The new index is visible in the cycle after the strobe.
- R3: An increment pulse while the queue is not empty advances the user pointer by one, wrapping from DEPTH-1 to 0. It leaves the write index unchanged unless a store is accepted in the same cycle.
- R4: The not-empty flag is 1 exactly when the occupancy is at least one.
- R5: The half-full flag is 1 exactly when the occupancy is at least DEPTH/2 (8 with the default depth of 16).
- R6: The full flag is 1 exactly when the occupancy equals DEPTH.
- R7: A store strobe while full is discarded: the write index and the occupancy do not change, and the overflow flag is set.
- R8: Once set, the overflow flag stays set until either a clear pulse arrives or an accepted increment empties the queue. If a set and a clear happen in the same cycle, the set wins.
- R9: An increment pulse while the queue is empty is ignored: the user address and all flags are unchanged.
- R10: A store and an increment in the same cycle, while the queue is neither empty nor full, advance both pointers and leave the occupancy unchanged.
- R11: The user address always equals BASE_ADDR plus the user pointer times OBJ_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| store_i | input | 1 | One-cycle strobe from the protocol engine: a frame has been written at wr_idx_o |
| inc_i | input | 1 | One-cycle software pulse: the object at user_addr_o has been consumed |
| ovf_clr_i | input | 1 | One-cycle software pulse that clears the overflow flag |
| wr_idx_o | output | IDX_W (4) | Write index of the object that receives the next frame |
| user_addr_o | output | ADDR_W (12) | RAM byte address of the oldest unread object |
| ne_o | output | 1 | Not-empty flag |
| half_o | output | 1 | Half-full flag |
| full_o | output | 1 | Full flag |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
On every cycle, the assertions check the following:
- the reset state;
- that full implies both half-full and not-empty;
- the pointer movement for an accepted store and for an accepted increment;
- that a store is discarded while full and an increment is ignored while empty;
- that a simultaneous store and increment leaves the flags unchanged;
- that the overflow flag holds until it is cleared.

Some properties need an independent occupancy count and address arithmetic, so only the bench's scenarios can show them:
- the exact thresholds for half-full and full;
- the wrap of both pointers from the last object back to the first;
- the base-plus-offset user address;
- that an emptying increment clears the overflow flag.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic ne;
    logic half;
    logic full;
    logic ovf;
  } rxq_flags_t;
endpackage

// File: rtl/rxq_wrap_ctr.sv
module rxq_wrap_ctr #(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_n;

  generate
    if ((1 << IDX_W) == DEPTH) begin : g_pow2
      always_comb idx_n = idx + 1'b1;
    end else begin : g_mod
      always_comb idx_n = (idx == IDX_W'(DEPTH - 1)) ? '0 : idx + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) idx <= '0;
    else if (en) idx <= idx_n;
  end
endmodule

// File: rtl/rxq_occ_flags.sv
module rxq_occ_flags
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  logic       pop,
  input  logic       store_req,
  input  logic       ovf_clr,
  output rxq_flags_t flags
);
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             ovf_n;

  always_comb begin
    case ({push, pop})
      2'b10:   cnt_n = cnt + 1'b1;
      2'b01:   cnt_n = cnt - 1'b1;
      default: cnt_n = cnt;
    endcase
  end

  // set has priority over clear; emptying increment clears as well
  always_comb begin
    if (store_req && !push)                ovf_n = 1'b1;
    else if (ovf_clr)                      ovf_n = 1'b0;
    else if (pop && cnt_n == '0)           ovf_n = 1'b0;
    else                                   ovf_n = flags.ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      flags <= '0;
    end else begin
      cnt        <= cnt_n;
      flags.ne   <= (cnt_n != '0);
      flags.half <= (cnt_n >= CNT_W'(DEPTH / 2));
      flags.full <= (cnt_n == CNT_W'(DEPTH));
      flags.ovf  <= ovf_n;
    end
  end
endmodule

// File: rtl/rxq_addr_gen.sv
module rxq_addr_gen #(
  parameter int DEPTH     = 16,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h400,
  parameter int OBJ_BYTES = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(OBJ_BYTES);

  logic last;
  assign last = (rd_idx == IDX_W'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (rst)       addr <= BASE;
    else if (en)   addr <= last ? BASE : addr + STEP;
  end
endmodule

// File: rtl/rx_msg_fifo_ctrl.sv
module rx_msg_fifo_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h400,
  parameter int OBJ_BYTES = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              store_i,
  input  logic              inc_i,
  input  logic              ovf_clr_i,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [ADDR_W-1:0] user_addr_o,
  output logic              ne_o,
  output logic              half_o,
  output logic              full_o,
  output logic              ovf_o
);
  rxq_flags_t       flags;
  logic             push, pop;
  logic [IDX_W-1:0] rd_idx;

  assign push = store_i && !flags.full;
  assign pop  = inc_i && flags.ne;

  rxq_wrap_ctr #(.DEPTH(DEPTH)) u_wr_ctr (
    .clk(clk), .rst(rst), .en(push), .idx(wr_idx_o)
  );

  rxq_wrap_ctr #(.DEPTH(DEPTH)) u_rd_ctr (
    .clk(clk), .rst(rst), .en(pop), .idx(rd_idx)
  );

  rxq_occ_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .store_req(store_i), .ovf_clr(ovf_clr_i), .flags(flags)
  );

  rxq_addr_gen #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .OBJ_BYTES(OBJ_BYTES)
  ) u_addr (
    .clk(clk), .rst(rst), .en(pop), .rd_idx(rd_idx), .addr(user_addr_o)
  );

  assign ne_o   = flags.ne;
  assign half_o = flags.half;
  assign full_o = flags.full;
  assign ovf_o  = flags.ovf;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 12,
  parameter int BASE_ADDR = 'h400,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              store_i,
  input logic              inc_i,
  input logic              ovf_clr_i,
  input logic [IDX_W-1:0]  wr_idx_o,
  input logic [ADDR_W-1:0] user_addr_o,
  input logic              ne_o,
  input logic              half_o,
  input logic              full_o,
  input logic              ovf_o
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!ne_o && !half_o && !full_o && !ovf_o && wr_idx_o == '0 &&
             user_addr_o == ADDR_W'(BASE_ADDR)));

  assert_store_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (store_i && !full_o) |=> (wr_idx_o == IDX_W'($past(wr_idx_o) + 1'b1)) && ne_o);

  assert_inc_keeps_widx_R3: assert property (@(posedge clk) disable iff (rst)
    (inc_i && ne_o && !store_i) |=> $stable(wr_idx_o) && !full_o);

  assert_full_implies_R6: assert property (@(posedge clk) disable iff (rst)
    full_o |-> (half_o && ne_o));

  assert_half_implies_ne_R5: assert property (@(posedge clk) disable iff (rst)
    half_o |-> ne_o);

  assert_store_discard_R7: assert property (@(posedge clk) disable iff (rst)
    (store_i && full_o && !inc_i) |=> ($stable(wr_idx_o) && full_o && ovf_o));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !ovf_clr_i && !inc_i) |=> ovf_o);

  assert_empty_inc_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !ne_o && !store_i) |=> ($stable(user_addr_o) && !ne_o));

  assert_both_keep_flags_R10: assert property (@(posedge clk) disable iff (rst)
    (store_i && inc_i && ne_o && !full_o) |=>
      ($stable(ne_o) && $stable(half_o) && $stable(full_o)));
endmodule

bind rx_msg_fifo_ctrl rxq_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_rxq_checker (
  .clk(clk), .rst(rst), .store_i(store_i), .inc_i(inc_i), .ovf_clr_i(ovf_clr_i),
  .wr_idx_o(wr_idx_o), .user_addr_o(user_addr_o), .ne_o(ne_o), .half_o(half_o),
  .full_o(full_o), .ovf_o(ovf_o)
);

// File: tb/test_rx_msg_fifo_ctrl.sv
`timescale 1ns/1ps
module test_rx_msg_fifo_ctrl;
  localparam int DEPTH = 16;
  localparam int ADDR_W = 12;
  localparam int BASE = 'h400;
  localparam int OBJ = 16;

  logic clk = 0, rst = 1, store_i = 0, inc_i = 0, ovf_clr_i = 0;
  logic [3:0] wr_idx_o;
  logic [ADDR_W-1:0] user_addr_o;
  logic ne_o, half_o, full_o, ovf_o;

  int n_chk = 0, n_fail = 0;
  int m_cnt = 0, m_wr = 0, m_rd = 0;
  bit m_ovf = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_msg_fifo_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE), .OBJ_BYTES(OBJ))
    i_rx_msg_fifo_ctrl (.clk(clk), .rst(rst), .store_i(store_i), .inc_i(inc_i),
      .ovf_clr_i(ovf_clr_i), .wr_idx_o(wr_idx_o), .user_addr_o(user_addr_o),
      .ne_o(ne_o), .half_o(half_o), .full_o(full_o), .ovf_o(ovf_o));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 write index", int'(wr_idx_o), m_wr);
    chk("R11 user address", int'(user_addr_o), (BASE + m_rd * OBJ) % (1 << ADDR_W));
    chk("R4 not-empty", int'(ne_o), int'(m_cnt >= 1));
    chk("R5 half-full", int'(half_o), int'(m_cnt >= DEPTH / 2));
    chk("R6 full", int'(full_o), int'(m_cnt == DEPTH));
    chk("R8 overflow", int'(ovf_o), int'(m_ovf));
  endtask

  // drive at negedge, let one posedge pass, update model, check at next negedge
  task automatic step(bit s, bit i, bit c);
    bit push, pop;
    store_i = s; inc_i = i; ovf_clr_i = c;
    push = s && (m_cnt != DEPTH);
    pop  = i && (m_cnt != 0);
    @(posedge clk);
    @(negedge clk);
    store_i = 0; inc_i = 0; ovf_clr_i = 0;
    m_cnt = m_cnt + int'(push) - int'(pop);
    if (push) m_wr = (m_wr + 1) % DEPTH;
    if (pop)  m_rd = (m_rd + 1) % DEPTH;
    if (s && !push) m_ovf = 1;
    else if (c) m_ovf = 0;
    else if (pop && m_cnt == 0) m_ovf = 0;
    check_all();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 write index", int'(wr_idx_o), 0);
    chk("R1 user address", int'(user_addr_o), BASE);
    chk("R1 flags", int'({ne_o, half_o, full_o, ovf_o}), 0);

    // R9: increment while empty is ignored
    step(0, 1, 0);
    chk("R9 address unchanged", int'(user_addr_o), BASE);

    // fill to full, checking every threshold
    for (int k = 0; k < DEPTH; k++) step(1, 0, 0);
    chk("R6 full after DEPTH stores", int'(full_o), 1);
    chk("R2 index wrapped to 0", int'(wr_idx_o), 0);

    // R7: store while full discarded, overflow set
    step(1, 0, 0);
    chk("R7 index unchanged", int'(wr_idx_o), 0);
    chk("R7 overflow set", int'(ovf_o), 1);
    // R8: set beats clear
    step(1, 0, 1);
    chk("R8 set wins over clear", int'(ovf_o), 1);
    step(0, 0, 0);
    chk("R8 sticky", int'(ovf_o), 1);

    // R3: drain completely, overflow clears on empty
    for (int k = 0; k < DEPTH; k++) begin
      step(0, 1, 0);
      chk("R3 index unchanged by increment", int'(wr_idx_o), 0);
    end
    chk("R8 cleared by emptying", int'(ovf_o), 0);
    chk("R3 user pointer wrapped", int'(user_addr_o), BASE);

    // R10: simultaneous store and increment
    for (int k = 0; k < 5; k++) step(1, 0, 0);
    for (int k = 0; k < 20; k++) begin
      step(1, 1, 0);
      chk("R10 occupancy unchanged", int'(half_o), 0);
    end

    // R8: software clear
    for (int k = 0; k < 12; k++) step(1, 0, 0);
    chk("R8 overflow after excess", int'(ovf_o), 1);
    step(0, 0, 1);
    chk("R8 cleared by software", int'(ovf_o), 0);

    // near-exhaustive mixed sweep
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 31);
      step(r[0] | r[3], r[1] | (r[4] & r[2]), (r == 7));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule